// File: doc/BRIEF.md
# Break-Immediate Trap Control Unit

This unit decodes and executes a break-and-link-immediate instruction for a small 32-bit processor core. It also tracks an immediate-prefix instruction that can supply the upper half of the next instruction's target. When a break instruction is accepted, the unit forms the 32-bit target and checks privilege. It then produces a register write-back of the current PC, a PC redirect, updated machine-status bits and a reservation-clear pulse. If the privilege check fails, it instead produces a privileged-instruction exception with its cause code.

Two target addresses, 0x8 and 0x18, act as software-break vectors. They are exempt from the privilege check. Taking either of them saves the user-mode and virtual-mode bits into their shadow copies and then clears both bits. When debug support is on, a prefixed break whose low half is 0x18 still goes to 0x18.

The unit is fully pipelined with a fixed latency. An instruction may be accepted on every cycle, and each result appears a set number of cycles later. The core's register file, memory system and address translation sit outside this unit.

Top module: `brk_trap_unit`

## Requirements
- R1: A valid word is a break instruction only when insn[31:26] = 6'b101110 and insn[20:16] = 5'b01100. Any other word never raises out_valid.
- R2: The target is insn[15:0] sign-extended to 32 bits. If the instruction is prefixed, the target is {prefix_hi, insn[15:0]} instead. A prefix word has insn[31:26] = 6'b101100 and carries prefix_hi in insn[15:0].
- R3: A prefix applies only to the very next valid instruction, of any kind. Cycles with in_valid low do not consume it.
- R4: On normal execution the unit asserts wb_en with wb_idx = insn[25:21] and wb_data = in_pc, and asserts pc_we with next_pc = target.
- R5: On normal execution nxt_bip is 1 and resv_clr pulses. Status bits not otherwise named pass through unchanged.
- R6: If cfg_mmu = 1, cur_um = 1 and the target is neither 0x8 nor 0x18, the unit asserts exc_valid with exc_cause = 5'b00111. In that case wb_en, pc_we and resv_clr stay 0 and all five status outputs equal their inputs.
- R7: For target 0x8 or 0x18, the result is nxt_ums = cur_um, nxt_vms = cur_vm, nxt_um = 0 and nxt_vm = 0.
- R8: If cfg_dbg = 1 and a prefixed break has insn[15:0] = 16'h0018, the target is 0x18 whatever the prefix holds.
- R9: If cfg_mmu = 0, no exception is raised. For targets other than 0x8 and 0x18, the user and virtual mode bits and their copies pass through unchanged.
- R10: Results for an instruction accepted on clock edge k are presented after edge k+LATENCY-1, for one cycle only (3 edges for the default). Every output is 0 in cycles with no result.
- R11: After synchronous reset all outputs are 0 and any pending prefix is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_insn | input | 32 | Instruction word |
| in_pc | input | 32 | Address of the instruction |
| cfg_mmu | input | 1 | Address translation configured |
| cfg_dbg | input | 1 | Debug support enabled |
| cur_bip | input | 1 | Current break-in-progress bit |
| cur_um | input | 1 | Current user-mode bit |
| cur_ums | input | 1 | Current saved user-mode bit |
| cur_vm | input | 1 | Current virtual-mode bit |
| cur_vms | input | 1 | Current saved virtual-mode bit |
| out_valid | output | 1 | A break instruction completes this cycle |
| wb_en | output | 1 | Register write-back enable |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 32 | Link value (instruction PC) |
| pc_we | output | 1 | PC redirect enable |
| next_pc | output | 32 | Redirect target |
| nxt_bip | output | 1 | New break-in-progress bit |
| nxt_um | output | 1 | New user-mode bit |
| nxt_ums | output | 1 | New saved user-mode bit |
| nxt_vm | output | 1 | New virtual-mode bit |
| nxt_vms | output | 1 | New saved virtual-mode bit |
| resv_clr | output | 1 | Load/store reservation clear pulse |
| exc_valid | output | 1 | Privileged-instruction exception |
| exc_cause | output | 5 | Exception cause code |

## Verification
The assertions check four properties on every cycle:
- the fixed result latency against a shadow of accepted break words;
- that an exception never comes with a write-back, redirect or reservation clear, and always carries cause 00111;
- that any redirect sets the break bit and clears the reservation;
- that a redirect to either software-break vector leaves both mode bits clear.

Some behaviour is visible only in the bench's scenarios, because it depends on the history of instruction words:
- which target is formed, including sign extension and prefix lifetime;
- the debug-mode exemption for 0x18;
- whether the privilege decision is right for a given mode and configuration;
- that the saved mode copies hold the old mode values.

// File: rtl/brk_pkg.sv
// Package: shared widths, encodings and the result record for the
// break-immediate trap unit. Assumes a 32-bit core with 32 registers.
package brk_pkg;
    localparam int XLEN    = 32;
    localparam int RIDX_W  = 5;
    localparam int IMM_W   = 16;
    localparam int CAUSE_W = 5;
    localparam int OPC_W   = 6;

    localparam logic [OPC_W-1:0]   OPC_BRK   = 6'b101110;
    localparam logic [OPC_W-1:0]   OPC_PFX   = 6'b101100;
    localparam logic [RIDX_W-1:0]  BRK_SUBOP = 5'b01100;
    localparam logic [CAUSE_W-1:0] CAUSE_PRIV = 5'b00111;
    localparam logic [XLEN-1:0]    VEC_SWBRK_A = 32'h0000_0008;
    localparam logic [XLEN-1:0]    VEC_SWBRK_B = 32'h0000_0018;
    localparam int NUM_VEC = 2;

    typedef struct packed {
        logic               vld;
        logic               wb_en;
        logic [RIDX_W-1:0]  wb_idx;
        logic [XLEN-1:0]    wb_data;
        logic               pc_we;
        logic [XLEN-1:0]    next_pc;
        logic               bip;
        logic               um;
        logic               ums;
        logic               vm;
        logic               vms;
        logic               resv_clr;
        logic               exc;
        logic [CAUSE_W-1:0] cause;
    } brk_res_t;
endpackage

// File: rtl/brk_decode.sv
// Module: field decoder. Splits an instruction word into the fields the
// unit needs and flags break and prefix words. Purely combinational;
// assumes bit 31 of the word is the most significant opcode bit.
module brk_decode
    import brk_pkg::*;
(
    input  logic [XLEN-1:0]   insn,
    output logic              is_brk,
    output logic              is_pfx,
    output logic [RIDX_W-1:0] rd,
    output logic [IMM_W-1:0]  imm
);
    localparam int OPC_LSB = XLEN - OPC_W;
    localparam int RD_LSB  = OPC_LSB - RIDX_W;
    localparam int SUB_LSB = RD_LSB - RIDX_W;

    // Field extraction and instruction class flags.
    always_comb begin
        rd     = insn[RD_LSB +: RIDX_W];
        imm    = insn[IMM_W-1:0];
        is_brk = (insn[OPC_LSB +: OPC_W] == OPC_BRK) &&
                 (insn[SUB_LSB +: RIDX_W] == BRK_SUBOP);
        is_pfx = (insn[OPC_LSB +: OPC_W] == OPC_PFX);
    end
endmodule

// File: rtl/brk_prefix_reg.sv
// Module: prefix holder. Captures the upper target half from a prefix
// word and keeps it for exactly the next accepted instruction. Cycles
// without an accepted word leave it untouched.
module brk_prefix_reg
    import brk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             is_pfx,
    input  logic [IMM_W-1:0] imm,
    output logic             pfx_vld,
    output logic [IMM_W-1:0] pfx_hi
);
    // Arm on a prefix word, disarm on any other accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pfx_vld <= 1'b0;
            pfx_hi  <= '0;
        end else if (take) begin
            pfx_vld <= is_pfx;
            if (is_pfx) pfx_hi <= imm;
        end
    end
endmodule

// File: rtl/brk_exec.sv
// Module: execution logic. Forms the target, runs the privilege check
// with its software-break exemption and builds the result record.
// Combinational; assumes the prefix state seen is that before this word.
module brk_exec
    import brk_pkg::*;
(
    input  logic              fire,
    input  logic [RIDX_W-1:0] rd,
    input  logic [IMM_W-1:0]  imm,
    input  logic [XLEN-1:0]   pc,
    input  logic              pfx_vld,
    input  logic [IMM_W-1:0]  pfx_hi,
    input  logic              cfg_mmu,
    input  logic              cfg_dbg,
    input  logic              cur_bip,
    input  logic              cur_um,
    input  logic              cur_ums,
    input  logic              cur_vm,
    input  logic              cur_vms,
    output brk_res_t          res
);
    localparam int HI_W = XLEN - IMM_W;
    localparam logic [XLEN-1:0] VECS [NUM_VEC] = '{VEC_SWBRK_A, VEC_SWBRK_B};

    logic [XLEN-1:0]    target;
    logic [NUM_VEC-1:0] vec_hit;
    logic               sw_brk;
    logic               priv_fault;

    // Target formation with the debug exemption for the second vector.
    always_comb begin
        if (pfx_vld) target = {pfx_hi, imm};
        else         target = {{HI_W{imm[IMM_W-1]}}, imm};
        if (cfg_dbg && pfx_vld && (imm == VEC_SWBRK_B[IMM_W-1:0]))
            target = VEC_SWBRK_B;
    end

    // One comparator per software-break vector.
    genvar v;
    generate
        for (v = 0; v < NUM_VEC; v++) begin : g_vec
            assign vec_hit[v] = (target == VECS[v]);
        end
    endgenerate

    assign sw_brk     = |vec_hit;
    assign priv_fault = cfg_mmu && cur_um && !sw_brk;

    // Result record: exception path, or link/redirect/status update.
    always_comb begin
        res = '0;
        if (fire) begin
            res.vld = 1'b1;
            res.bip = cur_bip;
            res.um  = cur_um;
            res.ums = cur_ums;
            res.vm  = cur_vm;
            res.vms = cur_vms;
            if (priv_fault) begin
                res.exc   = 1'b1;
                res.cause = CAUSE_PRIV;
            end else begin
                res.wb_en    = 1'b1;
                res.wb_idx   = rd;
                res.wb_data  = pc;
                res.pc_we    = 1'b1;
                res.next_pc  = target;
                res.bip      = 1'b1;
                res.resv_clr = 1'b1;
                if (sw_brk) begin
                    res.ums = cur_um;
                    res.um  = 1'b0;
                    res.vms = cur_vm;
                    res.vm  = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/brk_delay_pipe.sv
// Module: result delay line. Carries the result record through STAGES
// registers so every result leaves a fixed number of edges after
// acceptance. Assumes STAGES >= 1.
module brk_delay_pipe
    import brk_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  brk_res_t d,
    output brk_res_t q
);
    brk_res_t stg [STAGES];

    // Shift the record one stage per edge; reset empties every stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/brk_trap_unit.sv
// Module: top of the break-immediate trap unit. Wires decode, prefix
// holder, execution and delay line; results appear LATENCY edges after
// acceptance. Assumes status inputs are valid whenever in_valid is high.
module brk_trap_unit
    import brk_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [XLEN-1:0]    in_insn,
    input  logic [XLEN-1:0]    in_pc,
    input  logic               cfg_mmu,
    input  logic               cfg_dbg,
    input  logic               cur_bip,
    input  logic               cur_um,
    input  logic               cur_ums,
    input  logic               cur_vm,
    input  logic               cur_vms,
    output logic               out_valid,
    output logic               wb_en,
    output logic [RIDX_W-1:0]  wb_idx,
    output logic [XLEN-1:0]    wb_data,
    output logic               pc_we,
    output logic [XLEN-1:0]    next_pc,
    output logic               nxt_bip,
    output logic               nxt_um,
    output logic               nxt_ums,
    output logic               nxt_vm,
    output logic               nxt_vms,
    output logic               resv_clr,
    output logic               exc_valid,
    output logic [CAUSE_W-1:0] exc_cause
);
    logic              is_brk, is_pfx;
    logic [RIDX_W-1:0] rd;
    logic [IMM_W-1:0]  imm;
    logic              pfx_vld;
    logic [IMM_W-1:0]  pfx_hi;
    brk_res_t          res_now, res_out;

    brk_decode u_dec (
        .insn(in_insn), .is_brk(is_brk), .is_pfx(is_pfx), .rd(rd), .imm(imm)
    );

    brk_prefix_reg u_pfx (
        .clk(clk), .rst_n(rst_n), .take(in_valid), .is_pfx(is_pfx),
        .imm(imm), .pfx_vld(pfx_vld), .pfx_hi(pfx_hi)
    );

    brk_exec u_exe (
        .fire(in_valid && is_brk), .rd(rd), .imm(imm), .pc(in_pc),
        .pfx_vld(pfx_vld), .pfx_hi(pfx_hi),
        .cfg_mmu(cfg_mmu), .cfg_dbg(cfg_dbg),
        .cur_bip(cur_bip), .cur_um(cur_um), .cur_ums(cur_ums),
        .cur_vm(cur_vm), .cur_vms(cur_vms), .res(res_now)
    );

    brk_delay_pipe #(.STAGES(LATENCY)) u_pipe (
        .clk(clk), .rst_n(rst_n), .d(res_now), .q(res_out)
    );

    // Unpack the delayed record onto the ports.
    always_comb begin
        out_valid = res_out.vld;
        wb_en     = res_out.wb_en;
        wb_idx    = res_out.wb_idx;
        wb_data   = res_out.wb_data;
        pc_we     = res_out.pc_we;
        next_pc   = res_out.next_pc;
        nxt_bip   = res_out.bip;
        nxt_um    = res_out.um;
        nxt_ums   = res_out.ums;
        nxt_vm    = res_out.vm;
        nxt_vms   = res_out.vms;
        resv_clr  = res_out.resv_clr;
        exc_valid = res_out.exc;
        exc_cause = res_out.cause;
    end
endmodule

// File: rtl/brk_trap_unit_chk.sv
// Module: property checker for the trap unit, bound to every instance.
// Tracks accepted break words in a short shift register to check latency.
module brk_trap_unit_chk
    import brk_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [XLEN-1:0]    in_insn,
    input logic               out_valid,
    input logic               wb_en,
    input logic               pc_we,
    input logic [XLEN-1:0]    next_pc,
    input logic               nxt_bip,
    input logic               nxt_um,
    input logic               nxt_vm,
    input logic               resv_clr,
    input logic               exc_valid,
    input logic [CAUSE_W-1:0] exc_cause
);
    logic               seen;
    logic [LATENCY-1:0] shadow;

    assign seen = in_valid && (in_insn[31:26] == 6'b101110) &&
                  (in_insn[20:16] == 5'b01100);

    // Shadow of accepted break words, one bit per pipeline edge.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow <= '0;
        else        shadow <= (shadow << 1) | LATENCY'(seen);
    end

    a_r10_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == shadow[LATENCY-1]);

    a_r6_exc_blocks_update: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (!wb_en && !pc_we && !resv_clr));

    a_r6_exc_cause: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_cause == 5'b00111));

    a_r5_redirect_sets_bip: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> (nxt_bip && resv_clr && out_valid));

    a_r7_vector_clears_modes: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && (next_pc == 32'h8 || next_pc == 32'h18)) |-> (!nxt_um && !nxt_vm));

    a_r4_wb_with_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> pc_we);
endmodule

bind brk_trap_unit brk_trap_unit_chk #(.LATENCY(LATENCY)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .out_valid(out_valid), .wb_en(wb_en), .pc_we(pc_we), .next_pc(next_pc),
    .nxt_bip(nxt_bip), .nxt_um(nxt_um), .nxt_vm(nxt_vm),
    .resv_clr(resv_clr), .exc_valid(exc_valid), .exc_cause(exc_cause)
);

// File: tb/brk_trap_unit_tb.sv
// Bench: directed corner cases plus seeded random words, checked against
// a reference model written from the requirements.
module brk_trap_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 3;
    localparam int RW = 84;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_insn = '0;
    logic [31:0] in_pc = '0;
    logic        cfg_mmu = 1'b0, cfg_dbg = 1'b0;
    logic        cur_bip = 1'b0, cur_um = 1'b0, cur_ums = 1'b0, cur_vm = 1'b0, cur_vms = 1'b0;
    logic        out_valid, wb_en, pc_we, nxt_bip, nxt_um, nxt_ums, nxt_vm, nxt_vms;
    logic        resv_clr, exc_valid;
    logic [4:0]  wb_idx, exc_cause;
    logic [31:0] wb_data, next_pc;

    int checks = 0;
    int errors = 0;
    logic        m_pfx_vld = 1'b0;
    logic [15:0] m_pfx_hi = '0;
    string       m_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    brk_trap_unit #(.LATENCY(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
        .in_pc(in_pc), .cfg_mmu(cfg_mmu), .cfg_dbg(cfg_dbg),
        .cur_bip(cur_bip), .cur_um(cur_um), .cur_ums(cur_ums),
        .cur_vm(cur_vm), .cur_vms(cur_vms), .out_valid(out_valid),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .pc_we(pc_we),
        .next_pc(next_pc), .nxt_bip(nxt_bip), .nxt_um(nxt_um),
        .nxt_ums(nxt_ums), .nxt_vm(nxt_vm), .nxt_vms(nxt_vms),
        .resv_clr(resv_clr), .exc_valid(exc_valid), .exc_cause(exc_cause)
    );

    function automatic logic [31:0] mk_brk(input logic [4:0] rd, input logic [15:0] imm);
        return {6'b101110, rd, 5'b01100, imm};
    endfunction

    function automatic logic [31:0] mk_pfx(input logic [15:0] hi);
        return {6'b101100, 10'd0, hi};
    endfunction

    function automatic logic [RW-1:0] actual();
        return {out_valid, wb_en, wb_idx, wb_data, pc_we, next_pc, nxt_bip, nxt_um,
                nxt_ums, nxt_vm, nxt_vms, resv_clr, exc_valid, exc_cause};
    endfunction

    // Reference model; also sets m_tag to the requirement the case exercises.
    function automatic logic [RW-1:0] model(input logic [31:0] w, input logic [31:0] pc);
        logic [31:0] tgt;
        logic sw, fault;
        logic b, u, us, v, vs;
        m_tag = "R1";
        if (!(w[31:26] == 6'b101110 && w[20:16] == 5'b01100)) return '0;
        tgt = m_pfx_vld ? {m_pfx_hi, w[15:0]} : {{16{w[15]}}, w[15:0]};
        m_tag = m_pfx_vld ? "R2" : "R4";
        if (cfg_dbg && m_pfx_vld && w[15:0] == 16'h0018) begin
            tgt = 32'h18;
            m_tag = "R8";
        end
        sw = (tgt == 32'h8) || (tgt == 32'h18);
        fault = cfg_mmu && cur_um && !sw;
        if (!cfg_mmu && !sw) m_tag = "R9";
        if (fault) begin
            m_tag = "R6";
            return {1'b1, 1'b0, 5'd0, 32'd0, 1'b0, 32'd0, cur_bip, cur_um, cur_ums,
                    cur_vm, cur_vms, 1'b0, 1'b1, 5'b00111};
        end
        b = 1'b1; u = cur_um; us = cur_ums; v = cur_vm; vs = cur_vms;
        if (sw) begin
            us = cur_um; u = 1'b0; vs = cur_vm; v = 1'b0;
            if (m_tag != "R8") m_tag = "R7";
        end
        return {1'b1, 1'b1, w[25:21], pc, 1'b1, tgt, b, u, us, v, vs, 1'b1, 1'b0, 5'd0};
    endfunction

    task automatic check(input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Issue one word, wait out the latency, compare, then check the result is gone.
    task automatic issue(input logic [31:0] w, input logic [31:0] pc, input string tag);
        logic [RW-1:0] exp;
        string t;
        exp = model(w, pc);
        t = (tag == "") ? m_tag : tag;
        @(negedge clk);
        in_valid = 1'b1; in_insn = w; in_pc = pc;
        m_pfx_vld = (w[31:26] == 6'b101100);
        if (m_pfx_vld) m_pfx_hi = w[15:0];
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT-1) @(negedge clk);
        check(t, actual(), exp);
        @(negedge clk);
        check("R10", actual(), '0);
    endtask

    task automatic set_st(input logic mmu, input logic dbg, input logic um, input logic vm);
        cfg_mmu = mmu; cfg_dbg = dbg; cur_um = um; cur_vm = vm;
        cur_bip = 1'b0; cur_ums = ~um; cur_vms = ~vm;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] w;
        logic [15:0] imm;
        int sel;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", actual(), '0);

        // R4/R5: plain kernel-mode break, positive immediate
        set_st(1, 0, 0, 1);
        issue(mk_brk(5'd15, 16'h0120), 32'h0000_4000, "R4");
        // R2: negative immediate sign-extends
        issue(mk_brk(5'd3, 16'h8004), 32'h0000_4004, "R2");
        // R6: user mode, MMU on, ordinary target traps
        set_st(1, 0, 1, 1);
        issue(mk_brk(5'd7, 16'h0200), 32'h100, "R6");
        // R7: both vectors in user mode
        issue(mk_brk(5'd7, 16'h0008), 32'h104, "R7");
        set_st(1, 0, 1, 0);
        issue(mk_brk(5'd8, 16'h0018), 32'h108, "R7");
        // R9: no MMU, user mode, ordinary target, modes kept
        set_st(0, 0, 1, 1);
        issue(mk_brk(5'd9, 16'hFFF0), 32'h10C, "R9");
        // R2: prefixed target
        set_st(0, 0, 0, 0);
        issue(mk_pfx(16'hABCD), 32'h200, "R2");
        issue(mk_brk(5'd1, 16'h8000), 32'h204, "R2");
        // R3: prefix consumed by an unrelated word
        issue(mk_pfx(16'h1234), 32'h208, "R3");
        issue(32'h0000_0000, 32'h20C, "R3");
        issue(mk_brk(5'd2, 16'h0040), 32'h210, "R3");
        // R3: idle cycles do not consume the prefix
        issue(mk_pfx(16'h00FF), 32'h214, "R3");
        repeat (4) @(negedge clk);
        issue(mk_brk(5'd2, 16'h0040), 32'h218, "R3");
        // R8: debug on, prefixed 0x18 stays at the vector
        set_st(1, 1, 1, 1);
        issue(mk_pfx(16'h7777), 32'h300, "R8");
        issue(mk_brk(5'd4, 16'h0018), 32'h304, "R8");
        // R8 counterpart: debug off, prefix overrides so user mode traps
        set_st(1, 0, 1, 1);
        issue(mk_pfx(16'h7777), 32'h308, "R8");
        issue(mk_brk(5'd4, 16'h0018), 32'h30C, "R8");
        // R1: break opcode with the wrong sub-pattern is ignored
        issue({6'b101110, 5'd5, 5'b01101, 16'h0008}, 32'h400, "R1");
        // R11: reset discards a pending prefix
        set_st(0, 0, 0, 0);
        issue(mk_pfx(16'h5555), 32'h500, "R11");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_pfx_vld = 1'b0;
        check("R11", actual(), '0);
        issue(mk_brk(5'd6, 16'h0044), 32'h504, "R11");

        // Seeded random mix
        for (int n = 0; n < 400; n++) begin
            set_st(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            cur_bip = 1'($urandom); cur_ums = 1'($urandom); cur_vms = 1'($urandom);
            sel = $urandom_range(0, 9);
            case ($urandom_range(0, 3))
                0: imm = 16'h0008;
                1: imm = 16'h0018;
                default: imm = 16'($urandom);
            endcase
            if (sel < 5)      w = mk_brk(5'($urandom), imm);
            else if (sel < 7) w = mk_pfx(($urandom_range(0, 1) == 0) ? 16'h0 : 16'($urandom));
            else              w = $urandom;
            issue(w, $urandom, "");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule